// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects a vector of level-sensitive peripheral interrupt sources and reduces the enabled ones to a single cascade line. That line is wired into the highest-numbered input of a primary interrupt controller. Software turns sources on through a write-one-to-set port and turns them off through a separate write-one-to-clear port. Because the two ports are separate, software never needs a read-modify-write sequence to change one source. A masked status word shows which enabled sources are active, with bit n standing for source n.

A bypass register lets chosen sources skip the cascade entirely. When bypass bit n is set, source n drives primary input line n directly on the bypass output vector, and it is removed from the cascade OR. This holds even if the source is also enabled. The bypass path is not gated by the enable register; masking of those lines is left to the primary controller.

Register access uses a simple synchronous bus with separate write and read strobes and a 3-bit word address. Read data is registered: the word selected when `rd_en` is high is captured at that clock edge and held until the next read. A service loop that walks the pending bits from the lowest upward therefore works on a snapshot that does not change under it. The register decoder is a fixed set of named selectors, and the block has no sequential control states.

Top module: `sic_cascade`

## Requirements
- R1: After reset the enable and bypass registers are zero, `rd_data` is zero, `cascade_irq` is low and `bypass_irq` is zero, whatever the sources are.
- R2: A write to address 2 ORs the write data into the enable register. Zero bits in the write data leave their enable bits unchanged. A read of address 2 returns the enable register.
- R3: A write to address 3 clears every enable bit whose write-data bit is one. Writing all ones disables every source.
- R4: A read of address 0 returns the masked status, source AND enable, with bit n for source n.
- R5: `cascade_irq` is high exactly when some source is active, enabled and not bypassed. It follows the sources in the same cycle and follows register writes from the cycle after the write edge.
- R6: `bypass_irq[n]` equals source n AND bypass bit n, independent of the enable register.
- R7: A source whose bypass bit is set never raises `cascade_irq`, even when it is enabled.
- R8: Address 4 is the read/write bypass register, and a read returns the last value written.
- R9: Read data appears on `rd_data` in the cycle after `rd_en` and stays unchanged until the next read, even if the sources change.
- R10: A read of address 1 returns the raw source levels. Reads of unmapped addresses (5 to 7) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 32 | Level-sensitive source vector, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Registered read data |
| cascade_irq | output | 1 | Combined output to the primary controller's top input |
| bypass_irq | output | 32 | Direct lines to primary inputs, bit n for source n |

## Verification
The bench sets a source that is both enabled and bypassed and checks that it shows on its direct line while the cascade stays low. A design that forgot to remove bypassed sources would raise the cascade twice for one event. The bench also drives a bypassed source after all enables are cleared. This catches a design that wrongly gates the direct path with the enable register. It changes the sources after a status read to catch read data that tracks the live inputs instead of holding a snapshot. Finally, it writes zero bits to the set port, and writes to unmapped addresses, to show that neither write disturbs the enables or the bypass mask.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_RAW     = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_DISABLE = 3'd3,
        SEL_BYPASS  = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/sic_mask_regs.sv
module sic_mask_regs
    import sic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_SRC-1:0]  enable_q,
    output logic [N_SRC-1:0]  bypass_q
);
    logic [N_SRC-1:0] wbits;
    logic             hit_set;
    logic             hit_clr;
    logic             hit_byp;

    assign wbits   = wr_data[N_SRC-1:0];
    assign hit_set = wr_en && (wr_addr == SEL_ENABLE);
    assign hit_clr = wr_en && (wr_addr == SEL_DISABLE);
    assign hit_byp = wr_en && (wr_addr == SEL_BYPASS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (hit_set) begin
            enable_q <= enable_q | wbits;
        end else if (hit_clr) begin
            enable_q <= enable_q & ~wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bypass_q <= '0;
        end else if (hit_byp) begin
            bypass_q <= wbits;
        end
    end

    // R2: every bit written to the set port is enabled afterwards
    p_set_adds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((enable_q & $past(wbits)) == $past(wbits)));

    // R3: every bit written to the clear port is disabled afterwards
    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((enable_q & $past(wbits)) == '0));

    // R10: enables move only on writes to the set or clear port
    p_enable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_set || hit_clr) |=> $stable(enable_q));

    // R8: bypass mask moves only on its own write
    p_bypass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_byp |=> $stable(bypass_q));
endmodule

// File: rtl/sic_route.sv
module sic_route #(
    parameter int N_SRC = 32
) (
    input  logic [N_SRC-1:0] src_irq,
    input  logic [N_SRC-1:0] enable_q,
    input  logic [N_SRC-1:0] bypass_q,
    output logic [N_SRC-1:0] status,
    output logic [N_SRC-1:0] thru,
    output logic             cascade
);
    logic [N_SRC-1:0] combine_term;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign status[i]       = src_irq[i] & enable_q[i];
        assign combine_term[i] = status[i] & ~bypass_q[i];
        assign thru[i]         = src_irq[i] & bypass_q[i];
    end

    assign cascade = |combine_term;
endmodule

// File: rtl/sic_readback.sv
module sic_readback
    import sic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [N_SRC-1:0]  status,
    input  logic [N_SRC-1:0]  raw,
    input  logic [N_SRC-1:0]  enable_q,
    input  logic [N_SRC-1:0]  bypass_q,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        case (rd_addr)
            SEL_STATUS: rd_next = DATA_W'(status);
            SEL_RAW:    rd_next = DATA_W'(raw);
            SEL_ENABLE: rd_next = DATA_W'(enable_q);
            SEL_BYPASS: rd_next = DATA_W'(bypass_q);
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end

    // R9: read data is a snapshot held between reads
    p_snapshot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/sic_cascade.sv
module sic_cascade
    import sic_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_irq,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cascade_irq,
    output logic [N_SRC-1:0]  bypass_irq
);
    logic [N_SRC-1:0] enable_q;
    logic [N_SRC-1:0] bypass_q;
    logic [N_SRC-1:0] status;

    sic_mask_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .enable_q (enable_q),
        .bypass_q (bypass_q)
    );

    sic_route #(.N_SRC(N_SRC)) route_i (
        .src_irq  (src_irq),
        .enable_q (enable_q),
        .bypass_q (bypass_q),
        .status   (status),
        .thru     (bypass_irq),
        .cascade  (cascade_irq)
    );

    sic_readback #(.N_SRC(N_SRC), .DATA_W(DATA_W)) rdbk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .status   (status),
        .raw      (src_irq),
        .enable_q (enable_q),
        .bypass_q (bypass_q),
        .rd_data  (rd_data)
    );

    // R5: the cascade is only ever raised by an active source
    p_cascade_needs_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_irq |-> (src_irq != '0));

    // R6: a direct line is never high without its source
    p_thru_needs_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((bypass_irq & ~src_irq) == '0));

    // R7: a source on a direct line cannot also raise the cascade on its own
    p_no_double_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_irq & ~bypass_irq) == '0) |-> !cascade_irq);
endmodule

// File: tb/sic_cascade_tb_top.sv
module sic_cascade_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_irq = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        cascade_irq;
    logic [31:0] bypass_irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sic_cascade dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_irq     (src_irq),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .cascade_irq (cascade_irq),
        .bypass_irq  (bypass_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic drive_src(input logic [31:0] s);
        @(negedge clk);
        src_irq = s;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        drive_src(32'hFFFF_FFFF);
        check("R1 cascade", {31'd0, cascade_irq}, 32'd0);
        check("R1 bypass_irq", bypass_irq, 32'd0);
        check("R1 rd_data", rd_data, 32'd0);
        bus_read(3'd2, d); check("R1 enable", d, 32'd0);
        bus_read(3'd4, d); check("R1 bypass reg", d, 32'd0);
        drive_src(32'd0);
    endtask

    task automatic t_set();
        logic [31:0] d;
        bus_write(3'd2, 32'h0000_00F0);
        bus_write(3'd2, 32'h0000_0003);
        bus_read(3'd2, d); check("R2 set accumulates", d, 32'h0000_00F3);
        bus_write(3'd2, 32'h0000_0000);
        bus_read(3'd2, d); check("R2 zero write no effect", d, 32'h0000_00F3);
    endtask

    task automatic t_status();
        logic [31:0] d;
        drive_src(32'hA5A5_0050);
        bus_read(3'd0, d); check("R4 masked status", d, 32'h0000_0050);
        bus_read(3'd1, d); check("R10 raw sources", d, 32'hA5A5_0050);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        bus_read(3'd0, d); check("R9 status read", d, 32'h0000_0050);
        drive_src(32'h0000_0000);
        @(negedge clk); @(negedge clk);
        check("R9 snapshot held", rd_data, 32'h0000_0050);
    endtask

    task automatic t_cascade();
        drive_src(32'h0000_1000);
        check("R5 disabled source quiet", {31'd0, cascade_irq}, 32'd0);
        drive_src(32'h0000_0010);
        check("R5 enabled source raises", {31'd0, cascade_irq}, 32'd1);
        drive_src(32'h0000_0000);
        check("R5 idle", {31'd0, cascade_irq}, 32'd0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bus_write(3'd3, 32'h0000_0010);
        bus_read(3'd2, d); check("R3 single clear", d, 32'h0000_00E3);
        bus_write(3'd3, 32'hFFFF_FFFF);
        bus_read(3'd2, d); check("R3 clear all", d, 32'h0);
        drive_src(32'hFFFF_FFFF);
        check("R3 cascade after clear all", {31'd0, cascade_irq}, 32'd0);
        bus_read(3'd0, d); check("R3 status after clear all", d, 32'h0);
        drive_src(32'h0);
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        bus_write(3'd4, 32'hFFD0_0000);
        bus_read(3'd4, d); check("R8 bypass readback", d, 32'hFFD0_0000);
        bus_write(3'd2, 32'hFFFF_FFFF);
        drive_src(32'h0010_0000);
        check("R6 direct line", bypass_irq, 32'h0010_0000);
        check("R7 enabled bypassed excluded", {31'd0, cascade_irq}, 32'd0);
        drive_src(32'h0020_0000);
        check("R7 non bypassed cascades", {31'd0, cascade_irq}, 32'd1);
        check("R6 no direct for bit21", bypass_irq, 32'h0);
        bus_write(3'd3, 32'hFFFF_FFFF);
        drive_src(32'h8000_0000);
        check("R6 direct ignores enable", bypass_irq, 32'h8000_0000);
        check("R7 cascade low", {31'd0, cascade_irq}, 32'd0);
        drive_src(32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_read(3'd5, d); check("R10 unmapped read", d, 32'h0);
        bus_write(3'd5, 32'hFFFF_FFFF);
        bus_write(3'd7, 32'hFFFF_FFFF);
        bus_read(3'd2, d); check("R10 enable untouched", d, 32'h0);
        bus_read(3'd4, d); check("R10 bypass untouched", d, 32'hFFD0_0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set();
        t_status();
        t_hold();
        t_cascade();
        t_clear();
        t_bypass();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule